// File: doc/BRIEF.md
# Subsequence Store-and-Replay Preprocessor

This block sits on the element stream just before the output sequencer. Each element carries an update operation, a strobe flag, a duration count and a data value. An element can be marked for storage. It is then written into an indexed slot of an on-block memory and also forwarded downstream once. Unmarked elements pass straight through.

A replay command carries a length L and a repeat count R. It makes the block emit the L slots that end at the most recently written slot, in ascending slot order, R times over. A repeat count of zero repeats the run without end, which produces periodic output until the abort input or reset ends it. A stream may mix any number of replays with single elements before, between and after them.

The input and the output each use a valid/ready handshake. While a replay is being emitted the input is held off. Output backpressure pauses the replay without dropping or repeating anything.

Top module: `rpl_preproc`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and no slot counts as written.
- R2: An element with `in_kind` 2'b00, or the spare code 2'b11, appears unchanged (op, strobe, count, value) on the output in the cycle after it is accepted.
- R3: An element with `in_kind` 2'b01 is written to slot `in_slot`, becomes the most recent slot, and is forwarded once unchanged on the next cycle.
- R4: A command with `in_kind` 2'b10 emits slots last-L+1 through last in ascending order, repeated `in_rep_count` times. Every field of each stored element is kept.
- R5: L is clamped to last+1. With L of 0, or before any slot has been written, a replay emits nothing and the block is ready again one cycle later.
- R6: A repeat count of 0 repeats the run without end. Asserting `abort` ends the replay, and `in_ready` returns within two cycles.
- R7: `in_ready` stays low from the cycle after a non-empty replay is accepted until that replay ends.
- R8: While `out_valid` is high and `out_ready` is low, every output field holds its value. No element is lost or duplicated.
- R9: Replays that follow later stores use the new most recent slot. Single elements between replays keep their order in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort | input | 1 | Ends a replay in progress |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Input element accepted when high with in_valid |
| in_kind | input | 2 | 00 pass, 01 store, 10 replay, 11 pass |
| in_slot | input | $clog2(DEPTH) | Slot index for a store |
| in_op | input | OPW | Update operation code |
| in_strobe | input | 1 | Strobe flag |
| in_count | input | CW | Duration count |
| in_value | input | VW | Data value |
| in_rep_len | input | $clog2(DEPTH)+1 | Replay length L |
| in_rep_count | input | RW | Repeat count R, 0 means endless |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Downstream ready |
| out_op | output | OPW | Update operation code |
| out_strobe | output | 1 | Strobe flag |
| out_count | output | CW | Duration count |
| out_value | output | VW | Data value |

## Verification
The bench builds the block with DEPTH=8, RW=4, VW=16, CW=8 and OPW=4. With only eight slots, a length larger than the written run forces the clamp to last+1 after a few stores, and a slot index near the top of the memory is easy to reach. The small widths let each element's op, strobe and count be derived from its value, so a field dropped in storage shows up at once. An endless replay is run under held backpressure and then aborted, which covers the stall and termination paths together.

// File: rtl/rpl_pkg.sv
package rpl_pkg;
  typedef enum logic [1:0] {
    K_PASS   = 2'b00,
    K_STORE  = 2'b01,
    K_REPLAY = 2'b10,
    K_SPARE  = 2'b11
  } kind_e;
endpackage

// File: rtl/rpl_slot_mem.sv
module rpl_slot_mem #(
  parameter int DEPTH = 64,
  parameter int EW    = 53,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rpl_seq.sv
module rpl_seq #(
  parameter int DEPTH = 64,
  parameter int RW    = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int LW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic [RW-1:0] reps,
  input  logic [IW-1:0] last_idx,
  input  logic          have,
  input  logic          adv,
  input  logic          abort,
  output logic          busy,
  output logic [IW-1:0] rd_idx
);
  logic          busy_q, busy_d;
  logic [IW-1:0] ptr_q, ptr_d, first_q, first_d;
  logic [RW-1:0] left_q, left_d;
  logic          inf_q, inf_d;
  logic [LW-1:0] avail, eff;

  // number of slots that a replay may reach back over
  assign avail = have ? ({1'b0, last_idx} + LW'(1)) : '0;
  assign eff   = (len > avail) ? avail : len;

  always_comb begin
    busy_d  = busy_q;
    ptr_d   = ptr_q;
    first_d = first_q;
    left_d  = left_q;
    inf_d   = inf_q;
    if (abort) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d  = (eff != '0);
      first_d = last_idx - eff[IW-1:0] + IW'(1);
      ptr_d   = last_idx - eff[IW-1:0] + IW'(1);
      left_d  = reps;
      inf_d   = (reps == '0);
    end else if (busy_q && adv) begin
      if (ptr_q == last_idx) begin
        ptr_d = first_q;
        if (!inf_q) begin
          if (left_q == RW'(1)) busy_d = 1'b0;
          else                  left_d = left_q - RW'(1);
        end
      end else begin
        ptr_d = ptr_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ptr_q   <= '0;
      first_q <= '0;
      left_q  <= '0;
      inf_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      ptr_q   <= ptr_d;
      first_q <= first_d;
      left_q  <= left_d;
      inf_q   <= inf_d;
    end
  end

  assign busy   = busy_q;
  assign rd_idx = ptr_q;

  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy_q); // R6
  AST_PTR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (ptr_q <= last_idx) && (ptr_q >= first_q)); // R4
endmodule

// File: rtl/rpl_preproc.sv
module rpl_preproc
  import rpl_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int VW    = 32,
  parameter int CW    = 16,
  parameter int OPW   = 4,
  parameter int RW    = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int LW   = IW + 1,
  localparam int EW   = OPW + 1 + CW + VW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           abort,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [1:0]     in_kind,
  input  logic [IW-1:0]  in_slot,
  input  logic [OPW-1:0] in_op,
  input  logic           in_strobe,
  input  logic [CW-1:0]  in_count,
  input  logic [VW-1:0]  in_value,
  input  logic [LW-1:0]  in_rep_len,
  input  logic [RW-1:0]  in_rep_count,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [OPW-1:0] out_op,
  output logic           out_strobe,
  output logic [CW-1:0]  out_count,
  output logic [VW-1:0]  out_value
);
  logic [EW-1:0] in_elem, rd_elem, out_q, out_d;
  logic          ov_q, ov_d;
  logic [IW-1:0] last_q, last_d, rd_idx;
  logic          have_q, have_d;
  logic          busy, load, accept, is_store, is_replay, adv;

  assign in_elem   = {in_op, in_strobe, in_count, in_value};
  assign load      = !ov_q || out_ready;
  assign in_ready  = !busy && load;
  assign accept    = in_valid && in_ready;
  assign is_store  = (kind_e'(in_kind) == K_STORE);
  assign is_replay = (kind_e'(in_kind) == K_REPLAY);
  assign adv       = busy && load && !abort;

  rpl_slot_mem #(.DEPTH(DEPTH), .EW(EW)) u_mem (
    .clk   (clk),
    .we    (accept && is_store),
    .waddr (in_slot),
    .wdata (in_elem),
    .raddr (rd_idx),
    .rdata (rd_elem)
  );

  rpl_seq #(.DEPTH(DEPTH), .RW(RW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept && is_replay),
    .len      (in_rep_len),
    .reps     (in_rep_count),
    .last_idx (last_q),
    .have     (have_q),
    .adv      (adv),
    .abort    (abort),
    .busy     (busy),
    .rd_idx   (rd_idx)
  );

  always_comb begin
    out_d  = out_q;
    ov_d   = ov_q;
    last_d = last_q;
    have_d = have_q;
    if (load) ov_d = 1'b0;
    if (adv) begin
      out_d = rd_elem;
      ov_d  = 1'b1;
    end else if (accept && !is_replay) begin
      out_d = in_elem;
      ov_d  = 1'b1;
    end
    if (accept && is_store) begin
      last_d = in_slot;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      ov_q   <= 1'b0;
      last_q <= '0;
      have_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      ov_q   <= ov_d;
      last_q <= last_d;
      have_q <= have_d;
    end
  end

  assign out_valid = ov_q;
  assign {out_op, out_strobe, out_count, out_value} = out_q;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_q))); // R8
  AST_FWD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_replay) |=> (out_valid && out_q == $past(in_elem))); // R2
  AST_REPLAY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_replay && have_q && in_rep_len != '0 && !abort) |=> !in_ready); // R7
endmodule

// File: tb/tb_rpl_preproc.sv
`timescale 1ns/1ps
module tb_rpl_preproc;
  localparam int DEPTH = 8, VW = 16, CW = 8, OPW = 4, RW = 4;
  localparam int IW = $clog2(DEPTH), LW = IW + 1;

  logic clk = 0, rst_n = 0, abort = 0, in_valid = 0, out_ready = 1;
  logic [1:0] in_kind = 0;
  logic [IW-1:0] in_slot = 0;
  logic [OPW-1:0] in_op = 0;
  logic in_strobe = 0;
  logic [CW-1:0] in_count = 0;
  logic [VW-1:0] in_value = 0;
  logic [LW-1:0] in_rep_len = 0;
  logic [RW-1:0] in_rep_count = 0;
  logic in_ready, out_valid, out_strobe;
  logic [OPW-1:0] out_op;
  logic [CW-1:0] out_count;
  logic [VW-1:0] out_value;

  int checks = 0, fails = 0, obs_n = 0;
  logic [VW-1:0] obs_v [512];
  logic obs_ok [512];
  bit done = 0;

  always #5 clk = ~clk;

  rpl_preproc #(.DEPTH(DEPTH), .VW(VW), .CW(CW), .OPW(OPW), .RW(RW)) dut (.*);

  // per-element side fields derived from the value
  function automatic logic [OPW-1:0] f_op(logic [VW-1:0] v); return v[3:0] ^ 4'h5; endfunction
  function automatic logic [CW-1:0] f_cnt(logic [VW-1:0] v); return v[7:0] ^ 8'hA5; endfunction

  // {kind, slot, len, reps, value}
  localparam logic [28:0] STIM [11] = '{
    {2'b00, 3'd0, 4'd0, 4'd0, 16'h0011},
    {2'b01, 3'd0, 4'd0, 4'd0, 16'h0100},
    {2'b01, 3'd1, 4'd0, 4'd0, 16'h0101},
    {2'b01, 3'd2, 4'd0, 4'd0, 16'h0102},
    {2'b10, 3'd0, 4'd2, 4'd2, 16'h0000},
    {2'b11, 3'd0, 4'd0, 4'd0, 16'h0033},
    {2'b10, 3'd0, 4'd9, 4'd1, 16'h0000},
    {2'b10, 3'd0, 4'd0, 4'd3, 16'h0000},
    {2'b01, 3'd4, 4'd0, 4'd0, 16'h0204},
    {2'b01, 3'd5, 4'd0, 4'd0, 16'h0205},
    {2'b10, 3'd0, 4'd2, 4'd1, 16'h0000}
  };
  localparam int NEXP = 18;
  localparam logic [VW-1:0] EXP [NEXP] = '{
    16'h0011, 16'h0100, 16'h0101, 16'h0102, 16'h0101, 16'h0102, 16'h0101, 16'h0102,
    16'h0033, 16'h0100, 16'h0101, 16'h0102, 16'h0204, 16'h0205, 16'h0204, 16'h0205,
    16'h0044, 16'h0000
  };

  always begin
    @(negedge clk); #4;
    if (out_valid && out_ready) begin
      obs_v[obs_n]  = out_value;
      obs_ok[obs_n] = (out_op == f_op(out_value)) && (out_strobe == out_value[0])
                      && (out_count == f_cnt(out_value));
      obs_n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [IW-1:0] s, input logic [LW-1:0] l,
                      input logic [RW-1:0] r, input logic [VW-1:0] v);
    in_kind = k; in_slot = s; in_rep_len = l; in_rep_count = r; in_value = v;
    in_op = f_op(v); in_strobe = v[0]; in_count = f_cnt(v); in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic settle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      if (in_ready && !out_valid) quiet++; else quiet = 0;
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int base, cnt;
    logic [VW-1:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!out_valid, "R1 out_valid", out_valid, 0);
    check(in_ready, "R1 in_ready", in_ready, 1);
    rst_n = 1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R9
    foreach (STIM[i]) begin
      send(STIM[i][28:27], STIM[i][26:24], {1'b0, STIM[i][23:20]}, STIM[i][19:16], STIM[i][15:0]);
      if (i == 7) begin
        @(negedge clk);
        check(in_ready, "R5 ready after empty replay", in_ready, 1);
      end
    end
    send(2'b00, 0, 0, 0, 16'h0044);
    settle();
    check(obs_n == NEXP - 1, "R4 R9 stream length", obs_n, NEXP - 1);
    for (int i = 0; i < NEXP - 1; i++) begin
      check(obs_v[i] == EXP[i], "R2 R3 R4 R5 R9 stream value", obs_v[i], EXP[i]);
      check(obs_ok[i], "R4 fields kept", obs_ok[i], 1);
    end

    // R5: replay before any store
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    base = obs_n;
    send(2'b10, 0, 4'd3, 4'd2, 0);
    settle();
    check(obs_n == base, "R5 no store no output", obs_n - base, 0);

    // R6 R7 R8: endless replay with stall then abort
    send(2'b01, 0, 0, 0, 16'h0A0A);
    send(2'b01, 1, 0, 0, 16'h0B0B);
    settle();
    base = obs_n;
    send(2'b10, 0, 4'd2, 4'd0, 0);
    repeat (3) @(negedge clk);
    check(!in_ready, "R7 input held off", in_ready, 0);
    out_ready = 0;
    @(negedge clk);
    held = out_value;
    repeat (4) @(negedge clk);
    check(out_valid && out_value == held, "R8 stall hold", out_value, held);
    out_ready = 1;
    repeat (20) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    @(negedge clk); @(negedge clk);
    check(in_ready, "R6 abort ends replay", in_ready, 1);
    cnt = obs_n - base;
    check(cnt >= 10, "R6 endless repeat", cnt, 10);
    for (int i = 0; i < cnt; i++)
      check(obs_v[base + i] == ((i % 2 == 0) ? 16'h0A0A : 16'h0B0B), "R6 R8 order", obs_v[base + i],
            (i % 2 == 0) ? 16'h0A0A : 16'h0B0B);
    settle();
    check(obs_n == base + cnt, "R6 nothing after abort", obs_n - base, cnt);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule